// File: doc/BRIEF.md
# Debug Halt, Resume and Reset-and-Run Sequencer

This block drives a target processor's debug controller into one of three run states: halted, resumed, or reset and then running. It sits above a two-wire debug link engine, which it uses through a simple request/done handshake to perform single 32-bit register writes and reads. A command selects the operation. The block then issues that operation's fixed series of writes to the debug control register, and polls the debug status register until the operation's own two-bit field reads binary 11.

Each poll is a read of the status register. A read that fails, either because the field is not 11 or because the link flags a parity error, is retried after a fixed wait. After one read and five retries the operation stops and reports a timeout. The reset operation, once its poll succeeds, ends with three further writes, each followed by the same wait. The wait is a cycle count set by a parameter, so a fast clock can realise a 10 ms pause and a simulation can use a short one.

Top module: `dbgseq_top`

## Requirements
- R1: After reset `busy`, `done` and `link_req` are 0 and `result` is 00.
- R2: Halt (`cmd_op` = 01) writes 0x80000001 twice to control address 0x10, reads status address 0x11 until bits [9:8] are both 1, then writes 0x00000001 and reports ok.
- R3: Resume (`cmd_op` = 10) writes 0x80000001, 0x80000001, 0x00000001, 0x40000001 to 0x10, then reads 0x11 until bits [11:10] are both 1, and reports ok with no further write.
- R4: Reset-and-run (`cmd_op` = 11) writes 0x80000001, 0x80000001, 0x00000001, 0x00000003, polls bits [19:18], then writes 0x00000001, 0x10000001, 0x00000001; each of these last three writes is followed by a wait of at least `WAIT_CYCLES` cycles before the next step or the completion.
- R5: A poll read whose field is not 11 is retried after a wait of at least `WAIT_CYCLES` cycles; after `POLL_RETRIES`+1 failed reads the operation ends at once with `result` = 01 (timeout) and issues no later write. Writes that are not followed by a wait are issued with no such pause, and completion after a successful poll carries `result` = 00 (ok).
- R6: A status read returned with `link_perr` high counts as a failed poll attempt even when the field reads 11; it neither aborts nor succeeds.
- R7: `cmd_valid` is ignored while `busy` is high, and a command with `cmd_op` = 00 is ignored in idle.
- R8: `busy` is high from the cycle after a command is accepted until `done`; `done` is a one-cycle pulse with `busy` already low.
- R9: `link_req` stays high, with `link_wr`, `link_addr` and `link_wdata` unchanged, until the cycle in which `link_done` is seen; write requests use address 0x10 and read requests address 0x11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only in idle |
| cmd_op | input | 2 | 01 halt, 10 resume, 11 reset-and-run, 00 none |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 timeout; held until next completion |
| link_req | output | 1 | Request to the link engine, held until link_done |
| link_wr | output | 1 | 1 write, 0 read |
| link_addr | output | 7 | Debug register address |
| link_wdata | output | 32 | Write data |
| link_done | input | 1 | Link engine completion pulse |
| link_rdata | input | 32 | Read data, valid with link_done |
| link_perr | input | 1 | Parity error on the read, valid with link_done |

## Verification
The hardest situations to reach from the ports are the poll outcomes other than first-time success: a field with only one of its two bits set, a status word that satisfies another operation's field but not the current one, a parity-flagged read carrying a passing field, and an exhausted retry budget. The bench's link-engine model answers each status read from a per-test queue of words and parity flags, so every such case is scripted in advance and the expected series of link transactions, their spacing against the wait period, and the final result are pushed to the scoreboard before the command is given.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 7;
  localparam int IDX_W  = 4;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h10;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h11;

  localparam logic [WORD_W-1:0] W_ACTIVE_HALT = 32'h8000_0001;
  localparam logic [WORD_W-1:0] W_ACTIVE      = 32'h0000_0001;
  localparam logic [WORD_W-1:0] W_RESUME      = 32'h4000_0001;
  localparam logic [WORD_W-1:0] W_CORE_RST    = 32'h0000_0003;
  localparam logic [WORD_W-1:0] W_RST_ACK     = 32'h1000_0001;

  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_HALT   = 2'b01,
    OP_RESUME = 2'b10,
    OP_RESET  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SK_WR   = 2'b00,
    SK_POLL = 2'b01,
    SK_END  = 2'b10
  } step_kind_e;

  typedef struct packed {
    step_kind_e        kind;
    logic              pause;
    logic [WORD_W-1:0] data;
  } step_t;

  localparam logic [1:0] RES_OK      = 2'b00;
  localparam logic [1:0] RES_TIMEOUT = 2'b01;

  function automatic int field_lsb(op_e op);
    case (op)
      OP_HALT:   return 8;
      OP_RESUME: return 10;
      default:   return 18;
    endcase
  endfunction

endpackage

// File: rtl/dbgseq_steps.sv
module dbgseq_steps
  import dbgseq_pkg::*;
(
  input  op_e              op,
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  function automatic step_t mk(step_kind_e k, logic p, logic [WORD_W-1:0] d);
    step_t s;
    s.kind  = k;
    s.pause = p;
    s.data  = d;
    return s;
  endfunction

  always_comb begin
    step = mk(SK_END, 1'b0, '0);
    if (idx < 2) begin
      step = mk(SK_WR, 1'b0, W_ACTIVE_HALT);
    end else begin
      case (op)
        OP_HALT: begin
          case (idx)
            4'd2:    step = mk(SK_POLL, 1'b0, '0);
            4'd3:    step = mk(SK_WR, 1'b0, W_ACTIVE);
            default: step = mk(SK_END, 1'b0, '0);
          endcase
        end
        OP_RESUME: begin
          case (idx)
            4'd2:    step = mk(SK_WR, 1'b0, W_ACTIVE);
            4'd3:    step = mk(SK_WR, 1'b0, W_RESUME);
            4'd4:    step = mk(SK_POLL, 1'b0, '0);
            default: step = mk(SK_END, 1'b0, '0);
          endcase
        end
        OP_RESET: begin
          case (idx)
            4'd2:    step = mk(SK_WR, 1'b0, W_ACTIVE);
            4'd3:    step = mk(SK_WR, 1'b0, W_CORE_RST);
            4'd4:    step = mk(SK_POLL, 1'b0, '0);
            4'd5:    step = mk(SK_WR, 1'b1, W_ACTIVE);
            4'd6:    step = mk(SK_WR, 1'b1, W_RST_ACK);
            4'd7:    step = mk(SK_WR, 1'b1, W_ACTIVE);
            default: step = mk(SK_END, 1'b0, '0);
          endcase
        end
        default: step = mk(SK_END, 1'b0, '0);
      endcase
    end
  end
endmodule

// File: rtl/dbgseq_judge.sv
module dbgseq_judge
  import dbgseq_pkg::*;
(
  input  op_e               op,
  input  logic [WORD_W-1:0] rdata,
  input  logic              perr,
  output logic              pass
);
  logic [1:0] field;

  always_comb begin
    field = rdata[field_lsb(op) +: 2];
    pass  = !perr && (&field);
  end
endmodule

// File: rtl/dbgseq_wait.sv
module dbgseq_wait #(
  parameter int CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= RELOAD;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
  import dbgseq_pkg::*;
#(
  parameter int WAIT_CYCLES  = 1000000,
  parameter int POLL_RETRIES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic              link_req,
  output logic              link_wr,
  output logic [ADDR_W-1:0] link_addr,
  output logic [WORD_W-1:0] link_wdata,
  input  logic              link_done,
  input  logic [WORD_W-1:0] link_rdata,
  input  logic              link_perr
);
  localparam int TRY_W = $clog2(POLL_RETRIES + 1);
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(POLL_RETRIES);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_LINK, S_WAIT} state_e;

  state_e           state;
  op_e              op_q;
  logic [IDX_W-1:0] idx;
  logic [TRY_W-1:0] tries;
  logic             again;
  step_t            cur;
  logic             pass;
  logic             tm_load;
  logic             tm_expired;
  logic             poll_fail;

  dbgseq_steps u_steps (.op(op_q), .idx(idx), .step(cur));

  dbgseq_judge u_judge (.op(op_q), .rdata(link_rdata), .perr(link_perr), .pass(pass));

  dbgseq_wait #(.CYCLES(WAIT_CYCLES)) u_wait (
    .clk(clk), .rst(rst), .load(tm_load), .expired(tm_expired)
  );

  always_comb begin
    poll_fail = (cur.kind == SK_POLL) && !pass;
    tm_load   = (state == S_LINK) && link_done &&
                (((cur.kind == SK_WR) && cur.pause) || (poll_fail && (tries != LAST_TRY)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_NONE;
      idx        <= '0;
      tries      <= '0;
      again      <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      result     <= RES_OK;
      link_req   <= 1'b0;
      link_wr    <= 1'b0;
      link_addr  <= '0;
      link_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid && (op_e'(cmd_op) != OP_NONE)) begin
            op_q  <= op_e'(cmd_op);
            idx   <= '0;
            tries <= '0;
            busy  <= 1'b1;
            state <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (cur.kind == SK_END) begin
            done   <= 1'b1;
            busy   <= 1'b0;
            result <= RES_OK;
            state  <= S_IDLE;
          end else begin
            link_req   <= 1'b1;
            link_wr    <= (cur.kind == SK_WR);
            link_addr  <= (cur.kind == SK_WR) ? CTRL_ADDR : STAT_ADDR;
            link_wdata <= (cur.kind == SK_WR) ? cur.data : '0;
            state      <= S_LINK;
          end
        end
        S_LINK: begin
          if (link_done) begin
            link_req <= 1'b0;
            if (cur.kind == SK_WR) begin
              again <= 1'b0;
              if (cur.pause) begin
                state <= S_WAIT;
              end else begin
                idx   <= idx + 1'b1;
                state <= S_ISSUE;
              end
            end else if (!poll_fail) begin
              idx   <= idx + 1'b1;
              state <= S_ISSUE;
            end else if (tries == LAST_TRY) begin
              done   <= 1'b1;
              busy   <= 1'b0;
              result <= RES_TIMEOUT;
              state  <= S_IDLE;
            end else begin
              tries <= tries + 1'b1;
              again <= 1'b1;
              state <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (tm_expired) begin
            if (!again) idx <= idx + 1'b1;
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbgseq_chk.sv
module dbgseq_chk
  import dbgseq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic [1:0]        result,
  input logic              link_req,
  input logic              link_wr,
  input logic [ADDR_W-1:0] link_addr,
  input logic [WORD_W-1:0] link_wdata,
  input logic              link_done
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    link_req && !link_done |=> link_req);

  // R9
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    link_req && !link_done |=> $stable(link_addr) && $stable(link_wr) && $stable(link_wdata));

  // R9
  wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
    link_req && link_wr |-> link_addr == CTRL_ADDR);

  // R2
  rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    link_req && !link_wr |-> link_addr == STAT_ADDR);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !link_req);

  // R7
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));

  // R5
  result_code_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (result == RES_OK) || (result == RES_TIMEOUT));
endmodule

bind dbgseq_top dbgseq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .result(result), .link_req(link_req), .link_wr(link_wr), .link_addr(link_addr),
  .link_wdata(link_wdata), .link_done(link_done)
);

// File: tb/dbgseq_top_tb_top.sv
`timescale 1ns/1ps
module dbgseq_top_tb_top;
  import dbgseq_pkg::*;

  localparam int W = 20;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        busy, done;
  logic [1:0]  result;
  logic        link_req, link_wr;
  logic [6:0]  link_addr;
  logic [31:0] link_wdata;
  logic        link_done;
  logic [31:0] link_rdata;
  logic        link_perr;

  always #2.5 clk = ~clk;

  dbgseq_top #(.WAIT_CYCLES(W), .POLL_RETRIES(5)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .result(result),
    .link_req(link_req), .link_wr(link_wr), .link_addr(link_addr),
    .link_wdata(link_wdata), .link_done(link_done),
    .link_rdata(link_rdata), .link_perr(link_perr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // link engine model: scripted read responses
  typedef struct { logic perr; logic [31:0] data; } rsp_t;
  rsp_t rsp_q[$];
  logic [1:0] lcnt;

  always @(posedge clk) begin
    if (rst) begin
      link_done  <= 1'b0;
      lcnt       <= '0;
      link_rdata <= '0;
      link_perr  <= 1'b0;
    end else if (link_done) begin
      link_done <= 1'b0;
      lcnt      <= '0;
    end else if (link_req) begin
      if (lcnt == 2'd1) begin
        rsp_t r;
        link_done <= 1'b1;
        r.perr = 1'b0;
        r.data = '0;
        if (!link_wr && rsp_q.size() > 0) r = rsp_q.pop_front();
        link_rdata <= r.data;
        link_perr  <= r.perr;
      end else begin
        lcnt <= lcnt + 1'b1;
      end
    end
  end

  // scoreboard items; gapk: 0 any, 1 shorter than W, 2 at least W
  typedef struct {
    bit          is_res;
    logic [6:0]  addr;
    logic [31:0] data;
    logic        wr;
    logic [1:0]  code;
    int          gapk;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  task automatic push_wr(logic [31:0] d, int g, string req);
    exp_t e;
    e.is_res = 0; e.addr = 7'h10; e.data = d; e.wr = 1; e.code = 0; e.gapk = g; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic push_rd(int g, string req);
    exp_t e;
    e.is_res = 0; e.addr = 7'h11; e.data = 0; e.wr = 0; e.code = 0; e.gapk = g; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic push_res(logic [1:0] c, int g, string req);
    exp_t e;
    e.is_res = 1; e.addr = 0; e.data = 0; e.wr = 0; e.code = c; e.gapk = g; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic give(logic p, logic [31:0] d);
    rsp_t r;
    r.perr = p; r.data = d;
    rsp_q.push_back(r);
  endtask

  // monitor
  int cyc = 0;
  int last_ev = 0;
  logic prev_done = 0;
  logic prev_req = 0;
  logic [6:0]  cap_addr;
  logic [31:0] cap_data;

  task automatic gap_chk(exp_t e);
    int gap;
    gap = cyc - last_ev;
    if (e.gapk == 1) check(gap < W, e.req, "short gap", gap, W - 1);
    if (e.gapk == 2) check(gap >= W, e.req, "wait gap", gap, W);
    last_ev = cyc;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (link_req && !prev_req) begin
        cap_addr = link_addr;
        cap_data = link_wdata;
      end
      if (link_req && link_done) begin
        exp_t e;
        // R9: request fields unchanged from issue to completion
        check(cap_addr == link_addr && cap_data == link_wdata, "R9", "held request",
              {link_addr, link_wdata}, {cap_addr, cap_data});
        if (exp_q.size() == 0 || exp_q[0].is_res) begin
          check(0, "R7", "unexpected link transaction", {link_wr, link_addr, link_wdata}, 0);
        end else begin
          e = exp_q.pop_front();
          check(link_wr == e.wr && link_addr == e.addr && (!e.wr || link_wdata == e.data),
                e.req, "transaction", {link_wr, link_addr, link_wdata}, {e.wr, e.addr, e.data});
          gap_chk(e);
        end
      end
      if (done) begin
        exp_t e;
        // R8: single-cycle completion with busy low
        check(!prev_done && !busy, "R8", "done pulse", {prev_done, busy}, 0);
        if (exp_q.size() == 0 || !exp_q[0].is_res) begin
          check(0, "R7", "unexpected completion", result, 0);
        end else begin
          e = exp_q.pop_front();
          check(result == e.code, e.req, "result", result, e.code);
          gap_chk(e);
        end
      end
      prev_done = done;
      prev_req  = link_req;
    end
  end

  task automatic run(logic [1:0] op, bit poke, string req);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 0;
    // R8: busy from the cycle after acceptance
    check(busy == 1'b1, "R8", "busy after accept", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      cmd_valid = 1; cmd_op = 2'b11;   // R7: command while busy
      @(negedge clk);
      cmd_valid = 0;
    end
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, req, "items left", exp_q.size(), 0);
    rsp_q.delete();
  endtask

  task automatic halt_head(string req);
    push_wr(32'h8000_0001, 0, req);
    push_wr(32'h8000_0001, 1, req);
  endtask

  task automatic four_writes(logic [31:0] last, string req);
    push_wr(32'h8000_0001, 0, req);
    push_wr(32'h8000_0001, 1, req);
    push_wr(32'h0000_0001, 1, req);
    push_wr(last, 1, req);
  endtask

  task automatic reset_tail(string req);
    push_wr(32'h0000_0001, 1, req);
    push_wr(32'h1000_0001, 2, req);
    push_wr(32'h0000_0001, 2, req);
    push_res(2'b00, 2, req);
  endtask

  initial begin
    rst = 1; cmd_valid = 0; cmd_op = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(!busy && !done && !link_req && result == 2'b00, "R1", "reset outputs",
          {busy, done, link_req, result}, 0);

    // R2 basic halt, with a command poked mid-run (R7)
    halt_head("R2");
    push_rd(1, "R2");
    push_wr(32'h0000_0001, 1, "R2");
    push_res(2'b00, 1, "R2");
    give(0, 32'h0000_0300);
    run(2'b01, 1, "R2");

    // R5 single-bit fields fail, retried after a wait
    halt_head("R5");
    push_rd(1, "R5");
    push_rd(2, "R5");
    push_rd(2, "R5");
    push_wr(32'h0000_0001, 1, "R5");
    push_res(2'b00, 1, "R5");
    give(0, 32'h0000_0100);
    give(0, 32'h0000_0200);
    give(0, 32'h0000_0300);
    run(2'b01, 0, "R5");

    // R3 resume: halt field set is not enough, [11:10] needed
    four_writes(32'h4000_0001, "R3");
    push_rd(1, "R3");
    push_rd(2, "R3");
    push_res(2'b00, 1, "R3");
    give(0, 32'h0000_0300);
    give(0, 32'h0000_0C00);
    run(2'b10, 0, "R3");

    // R4 reset-and-run with timed cleanup
    four_writes(32'h0000_0003, "R4");
    push_rd(1, "R4");
    reset_tail("R4");
    give(0, 32'h000C_0000);
    run(2'b11, 0, "R4");

    // R6 parity error on a passing field is a failed attempt
    four_writes(32'h0000_0003, "R6");
    push_rd(1, "R6");
    push_rd(2, "R6");
    reset_tail("R6");
    give(1, 32'h000C_0000);
    give(0, 32'h000C_0000);
    run(2'b11, 0, "R6");

    // R5 timeout after one read and five retries, no closing write
    halt_head("R5");
    push_rd(1, "R5");
    for (int i = 0; i < 5; i++) push_rd(2, "R5");
    push_res(2'b01, 1, "R5");
    for (int i = 0; i < 6; i++) give(0, 32'h0000_0000);
    give(0, 32'h0000_0300);
    run(2'b01, 0, "R5");

    // R7 op 00 is ignored
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b00;
    @(negedge clk);
    cmd_valid = 0;
    repeat (10) @(negedge clk);
    check(!busy && !link_req, "R7", "no-op command", {busy, link_req}, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule